// File: doc/BRIEF.md
# Accumulator ALU with Banked Carry/Zero Flags

This block is the arithmetic unit of a small 8-bit controller core. It keeps the accumulator and performs one operation per cycle between the accumulator and an operand supplied by the sequencer: load, store, add, subtract, compare, AND, increment, decrement, complement and rotate left through carry. Operand fetch and address generation happen elsewhere. Values written back to memory (store, increment and decrement) leave on a result bus with a one-cycle write strobe.

Only two status bits exist, carry (C) and zero (Z). There are three copies of them: one for normal execution, one for interrupt service and one for non-maskable interrupt service. The processor mode input picks the copy that operations read and update and that appears on the flag outputs. When an interrupt is entered, the sequencer pulses a bank-load strobe that seeds the target copy from the normal copy. Returning is just a change of mode, which brings back the earlier copy as it was. The accumulator also sits in the data space at the top address, so a memory-mapped write there loads it.

All state changes on the rising clock edge that samples an operation. The new accumulator, flags, result and strobe can be seen straight after that edge.

Top module: `acc_flag_alu`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator, the result and result_we are 0, and C and Z are 0 in all three banks.
- R2: ADD (code 2) sets A to A+operand mod 256, with C as the carry out. SUB (code 3) sets A to A−operand. CP (code 4) computes A−operand and does not write A. For all three, Z is set exactly when the 8-bit result is 0. For SUB and CP with SUB_BORROW=1, C is 1 exactly when operand > A. With SUB_BORROW=0, C is 0 exactly when operand > A.
- R3: LD (code 0) sets A to the operand and AND (code 5) sets A to A&operand. Both set Z from the new A and leave C unchanged.
- R4: ST (code 1) drives result with A. INC (code 6) drives operand+1 and DEC (code 7) drives operand−1, both mod 256. In each case result_we is high for exactly the one cycle after the edge, Z is set when the driven value is 0, and both A and C are unchanged. Any other operation or an idle cycle leaves result_we low and the result held.
- R5: COM (code 8) sets C to the old bit 7 of A, replaces A with ~A, and sets Z from the new A.
- R6: RLC (code 9) shifts A left by one, with the old C going into bit 0 and the old bit 7 going to C. Z is unchanged.
- R7: cpu_mode 00 selects the normal bank, 01 the interrupt bank, and 10 or 11 the NMI bank. The carry and zero outputs show the selected bank. An operation changes only the selected bank.
- R8: A bank_load strobe copies the normal bank's C and Z into the selected bank. An operation in the same cycle works on the copied values. The other banks keep their values across mode changes.
- R9: A write with wr_en high to address 255 (all address bits 1) loads wr_data into A and leaves the flags unchanged. Writes to other addresses have no effect. If an operation writes A in the same cycle, the operation wins.
- R10: Codes 10 to 15 change no accumulator, flag, result or result_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 4 | Operation code |
| operand | input | 8 | Second operand |
| cpu_mode | input | 2 | Processor mode, selects the flag bank |
| bank_load | input | 1 | Seed the selected bank from the normal bank |
| wr_en | input | 1 | Memory-mapped data write strobe |
| wr_addr | input | 8 | Memory-mapped write address |
| wr_data | input | 8 | Memory-mapped write data |
| acc_q | output | 8 | Accumulator |
| result | output | 8 | Value to write back to memory |
| result_we | output | 1 | Write strobe for result |
| carry | output | 1 | Carry of the active bank |
| zero | output | 1 | Zero of the active bank |

## Verification
The bench builds two copies side by side and drives them with identical stimulus: one with SUB_BORROW=1 and one with SUB_BORROW=0, both at the default 8-bit width. Subtractions and compares in both carry conventions are therefore checked together. Because RLC reads C, any difference in the carry left by a subtraction shows up later in the accumulator of the affected copy. Both copies also run the bank-entry and mode-return sequences, so the two conventions are exercised in every bank.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_LD  = 4'd0,
    OP_ST  = 4'd1,
    OP_ADD = 4'd2,
    OP_SUB = 4'd3,
    OP_CP  = 4'd4,
    OP_AND = 4'd5,
    OP_INC = 4'd6,
    OP_DEC = 4'd7,
    OP_COM = 4'd8,
    OP_RLC = 4'd9
  } alu_op_e;

  localparam int NBANK = 3;
  typedef logic [1:0] bank_idx_t;

  function automatic bank_idx_t mode_to_bank(input logic [1:0] mode);
    case (mode)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W          = 8,
  parameter int SUB_BORROW = 1
) (
  input  logic         valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] opd,
  input  logic         c_in,
  output logic         acc_we,
  output logic [W-1:0] acc_nxt,
  output logic         res_we,
  output logic [W-1:0] res,
  output logic         upd_c,
  output logic         c_new,
  output logic         upd_z,
  output logic         z_new
);
  logic [W:0]   sum;
  logic [W:0]   diff;
  logic [W-1:0] inc_v;
  logic [W-1:0] dec_v;
  logic         sub_c;

  assign sum   = {1'b0, a} + {1'b0, opd};
  assign diff  = {1'b0, a} - {1'b0, opd};
  assign inc_v = opd + {{(W-1){1'b0}}, 1'b1};
  assign dec_v = opd - {{(W-1){1'b0}}, 1'b1};

  // carry convention for subtraction picked at build time
  if (SUB_BORROW != 0) begin : g_borrow
    assign sub_c = diff[W];
  end else begin : g_carry
    assign sub_c = ~diff[W];
  end

  always_comb begin
    acc_we  = 1'b0;
    acc_nxt = a;
    res_we  = 1'b0;
    res     = '0;
    upd_c   = 1'b0;
    c_new   = c_in;
    upd_z   = 1'b0;
    z_new   = 1'b0;
    if (valid) begin
      case (op)
        OP_LD: begin
          acc_we = 1'b1; acc_nxt = opd;
          upd_z = 1'b1;  z_new = (opd == '0);
        end
        OP_ST: begin
          res_we = 1'b1; res = a;
          upd_z = 1'b1;  z_new = (a == '0);
        end
        OP_ADD: begin
          acc_we = 1'b1; acc_nxt = sum[W-1:0];
          upd_c = 1'b1;  c_new = sum[W];
          upd_z = 1'b1;  z_new = (sum[W-1:0] == '0);
        end
        OP_SUB: begin
          acc_we = 1'b1; acc_nxt = diff[W-1:0];
          upd_c = 1'b1;  c_new = sub_c;
          upd_z = 1'b1;  z_new = (diff[W-1:0] == '0);
        end
        OP_CP: begin
          upd_c = 1'b1;  c_new = sub_c;
          upd_z = 1'b1;  z_new = (diff[W-1:0] == '0);
        end
        OP_AND: begin
          acc_we = 1'b1; acc_nxt = a & opd;
          upd_z = 1'b1;  z_new = ((a & opd) == '0);
        end
        OP_INC: begin
          res_we = 1'b1; res = inc_v;
          upd_z = 1'b1;  z_new = (inc_v == '0);
        end
        OP_DEC: begin
          res_we = 1'b1; res = dec_v;
          upd_z = 1'b1;  z_new = (dec_v == '0);
        end
        OP_COM: begin
          acc_we = 1'b1; acc_nxt = ~a;
          upd_c = 1'b1;  c_new = a[W-1];
          upd_z = 1'b1;  z_new = (a == {W{1'b1}});
        end
        OP_RLC: begin
          acc_we = 1'b1; acc_nxt = {a[W-2:0], c_in};
          upd_c = 1'b1;  c_new = a[W-1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_flag_bank.sv
module acc_flag_bank
  import acc_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bank_idx_t        sel,
  input  logic             copy_en,
  input  logic             upd_c,
  input  logic             c_new,
  input  logic             upd_z,
  input  logic             z_new,
  output logic             c_base,
  output logic             z_base,
  output logic [NBANK-1:0] c_all,
  output logic [NBANK-1:0] z_all
);
  // flags an operation starts from: seeded copy on entry, else own bank
  always_comb begin
    c_base = copy_en ? c_all[0] : c_all[sel];
    z_base = copy_en ? z_all[0] : z_all[sel];
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic en;
    logic c_d;
    logic z_d;
    logic c_q;
    logic z_q;

    always_comb begin
      en  = (sel == bank_idx_t'(b)) && (copy_en || upd_c || upd_z);
      c_d = upd_c ? c_new : c_base;
      z_d = upd_z ? z_new : z_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        c_q <= 1'b0;
        z_q <= 1'b0;
      end else if (en) begin
        c_q <= c_d;
        z_q <= z_d;
      end
    end

    assign c_all[b] = c_q;
    assign z_all[b] = z_q;
  end
endmodule

// File: rtl/acc_reg.sv
module acc_reg #(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_we,
  input  logic [W-1:0]  acc_nxt,
  input  logic          res_we,
  input  logic [W-1:0]  res,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  acc_q,
  output logic [W-1:0]  res_q,
  output logic          res_we_q
);
  localparam logic [AW-1:0] ACC_ADDR = {AW{1'b1}};

  logic         mmio_hit;
  logic         acc_en;
  logic [W-1:0] acc_d;

  always_comb begin
    mmio_hit = wr_en && (wr_addr == ACC_ADDR);
    acc_en   = acc_we || mmio_hit;
    acc_d    = acc_we ? acc_nxt : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_we) begin
      res_q <= res;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_we_q <= 1'b0;
    end else begin
      res_we_q <= res_we;
    end
  end
endmodule

// File: rtl/acc_flag_alu.sv
module acc_flag_alu
  import acc_alu_pkg::*;
#(
  parameter int W          = 8,
  parameter int AW         = 8,
  parameter int SUB_BORROW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [W-1:0]  operand,
  input  logic [1:0]    cpu_mode,
  input  logic          bank_load,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  acc_q,
  output logic [W-1:0]  result,
  output logic          result_we,
  output logic          carry,
  output logic          zero
);
  logic             rst_sync_n;
  bank_idx_t        bidx;
  logic             acc_we;
  logic [W-1:0]     acc_nxt;
  logic             res_we;
  logic [W-1:0]     res;
  logic             upd_c;
  logic             c_new;
  logic             upd_z;
  logic             z_new;
  logic             c_base;
  logic             z_base;
  logic [NBANK-1:0] c_all;
  logic [NBANK-1:0] z_all;

  assign bidx = mode_to_bank(cpu_mode);

  acc_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_alu_core #(.W(W), .SUB_BORROW(SUB_BORROW)) i_core (
    .valid   (op_valid),
    .op      (op_code),
    .a       (acc_q),
    .opd     (operand),
    .c_in    (c_base),
    .acc_we  (acc_we),
    .acc_nxt (acc_nxt),
    .res_we  (res_we),
    .res     (res),
    .upd_c   (upd_c),
    .c_new   (c_new),
    .upd_z   (upd_z),
    .z_new   (z_new)
  );

  acc_flag_bank i_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .sel     (bidx),
    .copy_en (bank_load),
    .upd_c   (upd_c),
    .c_new   (c_new),
    .upd_z   (upd_z),
    .z_new   (z_new),
    .c_base  (c_base),
    .z_base  (z_base),
    .c_all   (c_all),
    .z_all   (z_all)
  );

  acc_reg #(.W(W), .AW(AW)) i_acc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_we   (acc_we),
    .acc_nxt  (acc_nxt),
    .res_we   (res_we),
    .res      (res),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .acc_q    (acc_q),
    .res_q    (result),
    .res_we_q (result_we)
  );

  always_comb begin
    carry = c_all[bidx];
    zero  = z_all[bidx];
  end
endmodule

// File: rtl/acc_flag_alu_chk.sv
module acc_flag_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic [3:0]       op_code,
  input logic [1:0]       cpu_mode,
  input logic             bank_load,
  input logic             wr_en,
  input logic [W-1:0]     acc_q,
  input logic             result_we,
  input logic             carry,
  input logic             zero,
  input logic [NBANK-1:0] c_all,
  input logic [NBANK-1:0] z_all
);
  bank_idx_t bidx;
  logic      zonly_op;
  logic      store_op;

  always_comb begin
    bidx     = mode_to_bank(cpu_mode);
    store_op = (op_code == OP_ST) || (op_code == OP_INC) || (op_code == OP_DEC);
    zonly_op = store_op || (op_code == OP_LD) || (op_code == OP_AND);
  end

  AST_CP_HOLDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CP && !wr_en) |=> $stable(acc_q)); // R2

  AST_ZONLY_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && zonly_op && !bank_load) |=>
      (cpu_mode != $past(cpu_mode)) || (carry == $past(carry))); // R3

  AST_STROBE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    result_we |-> ($past(op_valid) && $past(store_op))); // R4

  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && store_op) |=> result_we); // R4

  AST_RLC_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_RLC && !bank_load) |=>
      (cpu_mode != $past(cpu_mode)) || (zero == $past(zero))); // R6

  AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !bank_load) |=> ($stable(c_all) && $stable(z_all))); // R7

  AST_NORMAL_BANK_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (bidx != 2'd0) |=> ($stable(c_all[0]) && $stable(z_all[0]))); // R7

  AST_ENTRY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_load && !op_valid) |=>
      (c_all[$past(bidx)] == $past(c_all[0])) &&
      (z_all[$past(bidx)] == $past(z_all[0]))); // R8

  AST_MMIO_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !op_valid && !bank_load) |=> ($stable(c_all) && $stable(z_all))); // R9

  AST_UNDEF_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > 4'd9 && !wr_en && !bank_load) |=>
      ($stable(acc_q) && $stable(c_all) && $stable(z_all) && !result_we)); // R10
endmodule

bind acc_flag_alu acc_flag_alu_chk #(.W(W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .cpu_mode  (cpu_mode),
  .bank_load (bank_load),
  .wr_en     (wr_en),
  .acc_q     (acc_q),
  .result_we (result_we),
  .carry     (carry),
  .zero      (zero),
  .c_all     (c_all),
  .z_all     (z_all)
);

// File: tb/test_acc_flag_alu.sv
`timescale 1ns/1ps
module test_acc_flag_alu;
  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] operand;
  logic [1:0] cpu_mode;
  logic       bank_load;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  logic [7:0] acc0, res0, acc1, res1;
  logic       we0, c0, z0, we1, c1, z1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // expected item: {result_we, result, acc, carry, zero}
  logic [18:0] q_b[$];
  logic [18:0] q_c[$];
  string       q_tag[$];

  // model state, index 0 = borrow convention, 1 = carry convention
  logic [7:0] m_acc [2];
  logic [7:0] m_res [2];
  logic       m_c   [2][3];
  logic       m_z   [2][3];

  acc_flag_alu #(.SUB_BORROW(1)) i_acc_flag_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .cpu_mode(cpu_mode), .bank_load(bank_load),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_q(acc0), .result(res0), .result_we(we0), .carry(c0), .zero(z0));

  acc_flag_alu #(.SUB_BORROW(0)) i_acc_flag_alu_carry (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .cpu_mode(cpu_mode), .bank_load(bank_load),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .acc_q(acc1), .result(res1), .result_we(we1), .carry(c1), .zero(z1));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic [18:0] act, input logic [18:0] exp,
                       input string tag, input string inst);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual we=%0b res=%02h acc=%02h c=%0b z=%0b expected we=%0b res=%02h acc=%02h c=%0b z=%0b",
               tag, inst, act[18], act[17:10], act[9:2], act[1], act[0],
               exp[18], exp[17:10], exp[9:2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input logic v, input logic [3:0] code, input logic [7:0] opd,
                       input logic [1:0] mode, input logic ld, input logic we,
                       input logic [7:0] addr, input logic [7:0] data, input string tag);
    int       bi;
    logic     c, z, accw, rw, under;
    logic [8:0] t;
    @(negedge clk);
    op_valid = v; op_code = code; operand = opd; cpu_mode = mode;
    bank_load = ld; wr_en = we; wr_addr = addr; wr_data = data;
    bi = (mode == 2'b00) ? 0 : (mode == 2'b01) ? 1 : 2;
    for (int k = 0; k < 2; k++) begin
      if (ld) begin
        m_c[k][bi] = m_c[k][0];
        m_z[k][bi] = m_z[k][0];
      end
      c = m_c[k][bi]; z = m_z[k][bi]; accw = 1'b0; rw = 1'b0;
      if (v) begin
        case (code)
          4'd0: begin m_acc[k] = opd; z = (opd == 8'h00); accw = 1'b1; end
          4'd1: begin m_res[k] = m_acc[k]; z = (m_acc[k] == 8'h00); rw = 1'b1; end
          4'd2: begin
            t = {1'b0, m_acc[k]} + {1'b0, opd};
            c = t[8]; m_acc[k] = t[7:0]; z = (t[7:0] == 8'h00); accw = 1'b1;
          end
          4'd3, 4'd4: begin
            under = (opd > m_acc[k]);
            t = {1'b0, m_acc[k] - opd};
            c = (k == 0) ? under : !under;
            z = (t[7:0] == 8'h00);
            if (code == 4'd3) begin m_acc[k] = t[7:0]; accw = 1'b1; end
          end
          4'd5: begin m_acc[k] = m_acc[k] & opd; z = (m_acc[k] == 8'h00); accw = 1'b1; end
          4'd6: begin m_res[k] = opd + 8'd1; z = (m_res[k] == 8'h00); rw = 1'b1; end
          4'd7: begin m_res[k] = opd - 8'd1; z = (m_res[k] == 8'h00); rw = 1'b1; end
          4'd8: begin c = m_acc[k][7]; m_acc[k] = ~m_acc[k]; z = (m_acc[k] == 8'h00); accw = 1'b1; end
          4'd9: begin
            t[0] = m_acc[k][7];
            m_acc[k] = {m_acc[k][6:0], c}; c = t[0]; accw = 1'b1;
          end
          default: ;
        endcase
      end
      if (we && addr == 8'hFF && !accw) m_acc[k] = data;
      m_c[k][bi] = c; m_z[k][bi] = z;
      if (k == 0) q_b.push_back({rw, m_res[k], m_acc[k], c, z});
      else        q_c.push_back({rw, m_res[k], m_acc[k], c, z});
    end
    q_tag.push_back(tag);
  endtask

  task automatic op(input logic [3:0] code, input logic [7:0] opd,
                    input logic [1:0] mode, input string tag);
    drive(1'b1, code, opd, mode, 1'b0, 1'b0, 8'h00, 8'h00, tag);
  endtask

  task automatic idle(input logic [1:0] mode, input string tag);
    drive(1'b0, 4'd0, 8'h00, mode, 1'b0, 1'b0, 8'h00, 8'h00, tag);
  endtask

  // monitor: pops one expected item per cycle after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q_tag.size() > 0) begin
        string tg;
        logic [18:0] eb, ec;
        tg = q_tag.pop_front();
        eb = q_b.pop_front();
        ec = q_c.pop_front();
        check({we0, res0, acc0, c0, z0}, eb, tg, "borrow");
        check({we1, res1, acc1, c1, z1}, ec, tg, "carry");
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_code = 4'd0; operand = 8'h00;
    cpu_mode = 2'b00; bank_load = 1'b0; wr_en = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    for (int k = 0; k < 2; k++) begin
      m_acc[k] = 8'h00; m_res[k] = 8'h00;
      for (int b = 0; b < 3; b++) begin m_c[k][b] = 1'b0; m_z[k][b] = 1'b0; end
    end
    repeat (3) @(negedge clk);
    check({we0, res0, acc0, c0, z0}, 19'd0, "R1 in reset", "borrow");
    check({we1, res1, acc1, c1, z1}, 19'd0, "R1 in reset", "carry");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    idle(2'b01, "R1 irq bank");
    idle(2'b10, "R1 nmi bank");
    idle(2'b00, "R1 normal bank");

    op(4'd0, 8'h00, 2'b00, "R3 LD zero");
    op(4'd0, 8'h80, 2'b00, "R3 LD nonzero");
    op(4'd2, 8'h90, 2'b00, "R2 ADD carry out");
    op(4'd2, 8'hF0, 2'b00, "R2 ADD to zero");
    op(4'd0, 8'h05, 2'b00, "R3 LD keeps C");
    op(4'd3, 8'h07, 2'b00, "R2 SUB underflow");
    op(4'd3, 8'hFE, 2'b00, "R2 SUB equal");
    op(4'd0, 8'h33, 2'b00, "R3 LD");
    op(4'd4, 8'h33, 2'b00, "R2 CP equal");
    op(4'd4, 8'h40, 2'b00, "R2 CP underflow");
    op(4'd5, 8'h0F, 2'b00, "R3 AND");
    op(4'd5, 8'h00, 2'b00, "R3 AND zero");

    op(4'd6, 8'hFF, 2'b00, "R4 INC wrap");
    op(4'd7, 8'h00, 2'b00, "R4 DEC wrap");
    op(4'd6, 8'h41, 2'b00, "R4 INC");
    op(4'd1, 8'h00, 2'b00, "R4 ST zero");
    idle(2'b00, "R4 strobe drops");
    op(4'd2, 8'h01, 2'b00, "R4 no strobe on ADD");

    op(4'd0, 8'hA5, 2'b00, "R5 setup");
    op(4'd8, 8'h00, 2'b00, "R5 COM msb set");
    op(4'd8, 8'h00, 2'b00, "R5 COM msb clear");
    op(4'd0, 8'hFF, 2'b00, "R5 setup ones");
    op(4'd8, 8'h00, 2'b00, "R5 COM to zero");
    op(4'd0, 8'hA5, 2'b00, "R6 setup");
    op(4'd9, 8'h00, 2'b00, "R6 RLC");
    op(4'd9, 8'h00, 2'b00, "R6 RLC carry in");
    op(4'd9, 8'h00, 2'b00, "R6 RLC again");

    op(4'd12, 8'h55, 2'b00, "R10 code 12");
    op(4'd15, 8'hAA, 2'b00, "R10 code 15");

    drive(1'b0, 4'd0, 8'h00, 2'b00, 1'b0, 1'b1, 8'hFF, 8'h77, "R9 mmio hit");
    drive(1'b0, 4'd0, 8'h00, 2'b00, 1'b0, 1'b1, 8'hFE, 8'h11, "R9 mmio miss");
    drive(1'b1, 4'd0, 8'h01, 2'b00, 1'b0, 1'b1, 8'hFF, 8'h99, "R9 op wins");
    drive(1'b1, 4'd4, 8'h50, 2'b00, 1'b0, 1'b1, 8'hFF, 8'h99, "R9 mmio with CP");

    op(4'd0, 8'h00, 2'b00, "R7 normal Z set");
    idle(2'b01, "R7 irq bank view");
    op(4'd2, 8'hF0, 2'b01, "R7 op in irq bank");
    idle(2'b00, "R7 normal untouched");
    drive(1'b0, 4'd0, 8'h00, 2'b10, 1'b1, 1'b0, 8'h00, 8'h00, "R8 nmi entry copy");
    op(4'd3, 8'hFF, 2'b10, "R8 op in nmi bank");
    idle(2'b00, "R8 return to normal");
    idle(2'b01, "R8 irq bank kept");
    drive(1'b1, 4'd9, 8'h00, 2'b01, 1'b1, 1'b0, 8'h00, 8'h00, "R8 entry with RLC");
    idle(2'b11, "R7 mode 11 is nmi");
    idle(2'b00, "R7 final normal");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule